// File: doc/BRIEF.md
# Display Link Bring-Up Sequencer

This block is a hardware state machine that brings a display transmitter's link up and takes it down again. A start request runs the bring-up sequence. If the stored settings are marked stale, the sequence first resets the PHY, has it configured, resets the core and has the core registers loaded. It then turns on PHY streaming and waits a bounded time for the PHY PLL to lock. After lock it moves the core clock from the pixel PLL to the PHY clock, keeping the clock gated during the move, and then enables the core and the timing generator. A stop request undoes the streaming state in reverse order.

All delays are counted in whole milliseconds from a prescaler, with the number of clocks per millisecond set by a parameter. A settings-stale flag is kept inside the block. It is set after reset and by an invalidate pulse, which the system raises when new settings are chosen or power to the transmitter was lost. It is cleared when a reload finishes. If the PLL does not lock in time, the sequence rolls back and an error flag is raised. The flag stays up until the next accepted start.

Top module: `link_bringup_seq`

## Requirements
- R1: After reset, phy_rst, phy_cfg_req, core_init_req, phy_stream_en, clk_sel, core_en, tg_en, link_up and err are 0. core_rst_n and clk_gate_en are 1, and cfg_dirty is 1.
- R2: A start accepted while cfg_dirty is 1 drives phy_rst high for exactly RST_MS*CLKS_PER_MS cycles. A wait of SETTLE_MS*CLKS_PER_MS cycles follows, then phy_cfg_req is high for one cycle.
- R3: Next, core_rst_n is low for RST_MS*CLKS_PER_MS cycles. A wait of SETTLE_MS*CLKS_PER_MS cycles follows, then core_init_req is high for one cycle. cfg_dirty falls in the cycle after that pulse.
- R4: A start accepted while cfg_dirty is 0 skips every reset and configure step and raises phy_stream_en in the next cycle.
- R5: While waiting for lock, phy_stream_en is 1 and phy_ready is sampled once at the last cycle of each millisecond. The wait ends after the first millisecond whose sample is 1, so it lasts k*CLKS_PER_MS cycles.
- R6: If POLL_TRIES samples in a row see phy_ready at 0, phy_stream_en falls and err rises in the same cycle, and the block returns to idle. err stays 1 until the next accepted start, which clears it.
- R7: After lock, each step lasts one cycle: clk_gate_en goes to 0; clk_sel goes to 1 with the clock still gated; clk_gate_en goes back to 1; core_en rises; tg_en rises; link_up rises and holds.
- R8: A stop accepted while streaming clears core_en, tg_en and link_up together. Then, one cycle per step: clk_gate_en falls; clk_sel returns to 0; clk_gate_en rises; phy_stream_en falls and the block is idle.
- R9: A cfg_invalidate pulse sets cfg_dirty in the next cycle in any state. It wins over a clear in the same cycle.
- R10: A start request is ignored unless the block is idle. A stop request is ignored unless it is streaming. No output changes because of an ignored request.
- R11: clk_sel only changes while clk_gate_en is 0, tg_en is never 1 without core_en, and core_en is only 1 with the PHY clock selected, running and streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to bring the link up |
| stop_req | input | 1 | Request to take the link down |
| cfg_invalidate | input | 1 | Marks stored settings stale (new settings or power lost) |
| phy_ready | input | 1 | PHY PLL lock indication |
| phy_rst | output | 1 | PHY software reset, active high |
| phy_cfg_req | output | 1 | One-cycle request to configure the PHY |
| core_rst_n | output | 1 | Core reset, active low |
| core_init_req | output | 1 | One-cycle request to load core registers and timings |
| phy_stream_en | output | 1 | PHY streaming enable |
| clk_gate_en | output | 1 | Core clock running (0 = gated) |
| clk_sel | output | 1 | Core clock source: 0 pixel PLL, 1 PHY clock |
| core_en | output | 1 | Core enable |
| tg_en | output | 1 | Timing generator enable |
| link_up | output | 1 | Sequence done, link streaming |
| err | output | 1 | PLL lock timeout seen |
| cfg_dirty | output | 1 | Stored settings are stale |

## Verification
The bench goes after the length of every timed phase down to the cycle. A prescaler that restarts late, or that counts one millisecond too many, would stretch a reset pulse or a settling wait, and the hold-time comparison would catch it. Lock is offered at different points within a millisecond and is never offered in the timeout run. A design that samples phy_ready every cycle would end the wait early, and one with an off-by-one retry limit would raise err at the wrong cycle. Start and stop are pulsed in the middle of a sequence, a start is sent while streaming and a stop while idle. A design that reacts to any of these would produce an output change the scoreboard does not expect. A start with clean settings checks that the reset phases are skipped, and a start after an invalidate checks that they come back.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_PHY_RST,
    S_PHY_SETTLE,
    S_PHY_CFG,
    S_CORE_RST,
    S_CORE_SETTLE,
    S_CORE_INIT,
    S_POLL,
    S_CLK_OFF,
    S_CLK_SWAP,
    S_CLK_ON,
    S_CORE_EN,
    S_TG_EN,
    S_STREAMING,
    S_OFF_EN,
    S_OFF_GATE,
    S_OFF_SWAP,
    S_OFF_UNGATE,
    S_OFF_PHY,
    S_FAIL
  } seq_state_e;

  typedef struct packed {
    logic phy_rst;
    logic phy_cfg_req;
    logic core_rst_n;
    logic core_init_req;
    logic phy_stream_en;
    logic clk_gate_en;
    logic clk_sel;
    logic core_en;
    logic tg_en;
    logic link_up;
  } seq_out_t;

endpackage

// File: rtl/lbs_ms_timer.sv
module lbs_ms_timer #(
  parameter int CLKS_PER_MS = 50000,
  parameter int MS_W        = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  output logic            tick,
  output logic [MS_W-1:0] ms_cnt
);

  logic [MS_W-1:0] ms_q, ms_d;
  logic            ms_en;

  generate
    if (CLKS_PER_MS > 1) begin : g_prescale
      localparam int CYC_W = $clog2(CLKS_PER_MS);
      localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CLKS_PER_MS - 1);
      logic [CYC_W-1:0] cyc_q, cyc_d;
      logic             cyc_en;

      always_comb begin
        cyc_en = restart | run;
        if (restart)               cyc_d = '0;
        else if (cyc_q == CYC_LAST) cyc_d = '0;
        else                       cyc_d = cyc_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cyc_q <= '0;
        else if (cyc_en) cyc_q <= cyc_d;
      end

      assign tick = run & (cyc_q == CYC_LAST);
    end else begin : g_direct
      assign tick = run;
    end
  endgenerate

  always_comb begin
    ms_en = restart | tick;
    if (restart) ms_d = '0;
    else         ms_d = ms_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ms_q <= '0;
    else if (ms_en) ms_q <= ms_d;
  end

  assign ms_cnt = ms_q;

endmodule

// File: rtl/lbs_seq_fsm.sv
module lbs_seq_fsm
  import lbs_pkg::*;
#(
  parameter int RST_MS     = 10,
  parameter int SETTLE_MS  = 10,
  parameter int POLL_TRIES = 100,
  parameter int MS_W       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_req,
  input  logic            stop_req,
  input  logic            cfg_invalidate,
  input  logic            phy_ready,
  input  logic            ms_tick,
  input  logic [MS_W-1:0] ms_cnt,
  output seq_state_e      state_q,
  output seq_state_e      state_d,
  output logic            tmr_run,
  output logic            tmr_restart,
  output logic            cfg_dirty,
  output logic            err
);

  localparam logic [MS_W-1:0] RST_LAST    = MS_W'(RST_MS - 1);
  localparam logic [MS_W-1:0] SETTLE_LAST = MS_W'(SETTLE_MS - 1);
  localparam logic [MS_W-1:0] POLL_LAST   = MS_W'(POLL_TRIES - 1);

  logic rst_done, settle_done, poll_ok, poll_timeout;
  logic dirty_q, dirty_d;
  logic err_q, err_d;
  logic start_ok;

  assign rst_done     = ms_tick & (ms_cnt == RST_LAST);
  assign settle_done  = ms_tick & (ms_cnt == SETTLE_LAST);
  assign poll_ok      = ms_tick & phy_ready;
  assign poll_timeout = ms_tick & ~phy_ready & (ms_cnt == POLL_LAST);
  assign start_ok     = (state_q == S_IDLE) & start_req;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:        if (start_req) state_d = dirty_q ? S_PHY_RST : S_POLL;
      S_PHY_RST:     if (rst_done) state_d = S_PHY_SETTLE;
      S_PHY_SETTLE:  if (settle_done) state_d = S_PHY_CFG;
      S_PHY_CFG:     state_d = S_CORE_RST;
      S_CORE_RST:    if (rst_done) state_d = S_CORE_SETTLE;
      S_CORE_SETTLE: if (settle_done) state_d = S_CORE_INIT;
      S_CORE_INIT:   state_d = S_POLL;
      S_POLL: begin
        if (poll_ok)           state_d = S_CLK_OFF;
        else if (poll_timeout) state_d = S_FAIL;
      end
      S_CLK_OFF:     state_d = S_CLK_SWAP;
      S_CLK_SWAP:    state_d = S_CLK_ON;
      S_CLK_ON:      state_d = S_CORE_EN;
      S_CORE_EN:     state_d = S_TG_EN;
      S_TG_EN:       state_d = S_STREAMING;
      S_STREAMING:   if (stop_req) state_d = S_OFF_EN;
      S_OFF_EN:      state_d = S_OFF_GATE;
      S_OFF_GATE:    state_d = S_OFF_SWAP;
      S_OFF_SWAP:    state_d = S_OFF_UNGATE;
      S_OFF_UNGATE:  state_d = S_OFF_PHY;
      S_OFF_PHY:     state_d = S_IDLE;
      S_FAIL:        state_d = S_IDLE;
      default:       state_d = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      S_PHY_RST, S_PHY_SETTLE, S_CORE_RST, S_CORE_SETTLE, S_POLL: tmr_run = 1'b1;
      default: tmr_run = 1'b0;
    endcase
  end

  assign tmr_restart = (state_d != state_q);

  // settings-stale flag: invalidate wins over the clear at the end of a reload
  always_comb begin
    if (cfg_invalidate)            dirty_d = 1'b1;
    else if (state_q == S_CORE_INIT) dirty_d = 1'b0;
    else                           dirty_d = dirty_q;
  end

  always_comb begin
    if (start_ok)              err_d = 1'b0;
    else if (state_d == S_FAIL) err_d = 1'b1;
    else                       err_d = err_q;
  end

  // state and flag registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dirty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dirty_q <= dirty_d;
      err_q   <= err_d;
    end
  end

  assign cfg_dirty = dirty_q;
  assign err       = err_q;

endmodule

// File: rtl/lbs_out_reg.sv
module lbs_out_reg
  import lbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state_d,
  output seq_out_t   out_q
);

  seq_out_t out_d;
  seq_out_t out_rst;

  always_comb begin
    out_rst             = '0;
    out_rst.core_rst_n  = 1'b1;
    out_rst.clk_gate_en = 1'b1;
  end

  always_comb begin
    out_d = out_rst;
    unique case (state_d)
      S_PHY_RST:    out_d.phy_rst       = 1'b1;
      S_PHY_CFG:    out_d.phy_cfg_req   = 1'b1;
      S_CORE_RST:   out_d.core_rst_n    = 1'b0;
      S_CORE_INIT:  out_d.core_init_req = 1'b1;
      S_POLL:       out_d.phy_stream_en = 1'b1;
      S_CLK_OFF: begin
        out_d.phy_stream_en = 1'b1;
        out_d.clk_gate_en   = 1'b0;
      end
      S_CLK_SWAP: begin
        out_d.phy_stream_en = 1'b1;
        out_d.clk_gate_en   = 1'b0;
        out_d.clk_sel       = 1'b1;
      end
      S_CLK_ON: begin
        out_d.phy_stream_en = 1'b1;
        out_d.clk_sel       = 1'b1;
      end
      S_CORE_EN: begin
        out_d.phy_stream_en = 1'b1;
        out_d.clk_sel       = 1'b1;
        out_d.core_en       = 1'b1;
      end
      S_TG_EN: begin
        out_d.phy_stream_en = 1'b1;
        out_d.clk_sel       = 1'b1;
        out_d.core_en       = 1'b1;
        out_d.tg_en         = 1'b1;
      end
      S_STREAMING: begin
        out_d.phy_stream_en = 1'b1;
        out_d.clk_sel       = 1'b1;
        out_d.core_en       = 1'b1;
        out_d.tg_en         = 1'b1;
        out_d.link_up       = 1'b1;
      end
      S_OFF_EN: begin
        out_d.phy_stream_en = 1'b1;
        out_d.clk_sel       = 1'b1;
      end
      S_OFF_GATE: begin
        out_d.phy_stream_en = 1'b1;
        out_d.clk_sel       = 1'b1;
        out_d.clk_gate_en   = 1'b0;
      end
      S_OFF_SWAP: begin
        out_d.phy_stream_en = 1'b1;
        out_d.clk_gate_en   = 1'b0;
      end
      S_OFF_UNGATE: out_d.phy_stream_en = 1'b1;
      default: out_d = out_rst;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= out_rst;
    else        out_q <= out_d;
  end

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import lbs_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000,
  parameter int RST_MS      = 10,
  parameter int SETTLE_MS   = 10,
  parameter int POLL_TRIES  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic stop_req,
  input  logic cfg_invalidate,
  input  logic phy_ready,
  output logic phy_rst,
  output logic phy_cfg_req,
  output logic core_rst_n,
  output logic core_init_req,
  output logic phy_stream_en,
  output logic clk_gate_en,
  output logic clk_sel,
  output logic core_en,
  output logic tg_en,
  output logic link_up,
  output logic err,
  output logic cfg_dirty
);

  localparam int MS_MAX_A = (RST_MS > SETTLE_MS) ? RST_MS : SETTLE_MS;
  localparam int MS_MAX   = (MS_MAX_A > POLL_TRIES) ? MS_MAX_A : POLL_TRIES;
  localparam int MS_W     = $clog2(MS_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  seq_state_e      state_q, state_d;
  logic            tmr_run, tmr_restart, ms_tick;
  logic [MS_W-1:0] ms_cnt;
  seq_out_t        outs;

  lbs_ms_timer #(
    .CLKS_PER_MS(CLKS_PER_MS),
    .MS_W       (MS_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (tmr_run),
    .restart(tmr_restart),
    .tick   (ms_tick),
    .ms_cnt (ms_cnt)
  );

  lbs_seq_fsm #(
    .RST_MS    (RST_MS),
    .SETTLE_MS (SETTLE_MS),
    .POLL_TRIES(POLL_TRIES),
    .MS_W      (MS_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .start_req     (start_req),
    .stop_req      (stop_req),
    .cfg_invalidate(cfg_invalidate),
    .phy_ready     (phy_ready),
    .ms_tick       (ms_tick),
    .ms_cnt        (ms_cnt),
    .state_q       (state_q),
    .state_d       (state_d),
    .tmr_run       (tmr_run),
    .tmr_restart   (tmr_restart),
    .cfg_dirty     (cfg_dirty),
    .err           (err)
  );

  lbs_out_reg u_outs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .state_d(state_d),
    .out_q  (outs)
  );

  assign phy_rst       = outs.phy_rst;
  assign phy_cfg_req   = outs.phy_cfg_req;
  assign core_rst_n    = outs.core_rst_n;
  assign core_init_req = outs.core_init_req;
  assign phy_stream_en = outs.phy_stream_en;
  assign clk_gate_en   = outs.clk_gate_en;
  assign clk_sel       = outs.clk_sel;
  assign core_en       = outs.core_en;
  assign tg_en         = outs.tg_en;
  assign link_up       = outs.link_up;

endmodule

// File: rtl/link_bringup_seq_chk.sv
module link_bringup_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic phy_rst,
  input logic phy_cfg_req,
  input logic core_rst_n,
  input logic phy_stream_en,
  input logic clk_gate_en,
  input logic clk_sel,
  input logic core_en,
  input logic tg_en,
  input logic link_up,
  input logic err
);

  // R11
  clk_swap_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_sel) |-> !clk_gate_en);

  // R11
  tg_needs_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tg_en |-> core_en);

  // R7
  tg_after_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tg_en) |-> $past(core_en));

  // R11
  core_on_phy_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> (clk_sel && clk_gate_en && phy_stream_en));

  // R2
  cfg_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_cfg_req |=> !phy_cfg_req);

  // R3
  resets_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phy_rst && !core_rst_n));

  // R6
  up_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> !err);

  // R8
  stream_off_clk_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_stream_en) |-> (!clk_sel && clk_gate_en && !core_en));

endmodule

bind link_bringup_seq link_bringup_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .phy_rst      (phy_rst),
  .phy_cfg_req  (phy_cfg_req),
  .core_rst_n   (core_rst_n),
  .phy_stream_en(phy_stream_en),
  .clk_gate_en  (clk_gate_en),
  .clk_sel      (clk_sel),
  .core_en      (core_en),
  .tg_en        (tg_en),
  .link_up      (link_up),
  .err          (err)
);

// File: tb/link_bringup_seq_bench.sv
`timescale 1ns/1ps
module link_bringup_seq_bench;

  localparam int CPM   = 5;
  localparam int RSTMS = 10;
  localparam int SETMS = 10;
  localparam int TRIES = 100;

  // vector bit positions used by the scoreboard
  localparam logic [11:0] B_PRST  = 12'h800;
  localparam logic [11:0] B_CFG   = 12'h400;
  localparam logic [11:0] B_RSTN  = 12'h200;
  localparam logic [11:0] B_INIT  = 12'h100;
  localparam logic [11:0] B_STR   = 12'h080;
  localparam logic [11:0] B_GATE  = 12'h040;
  localparam logic [11:0] B_SEL   = 12'h020;
  localparam logic [11:0] B_CORE  = 12'h010;
  localparam logic [11:0] B_TG    = 12'h008;
  localparam logic [11:0] B_UP    = 12'h004;
  localparam logic [11:0] B_ERR   = 12'h002;
  localparam logic [11:0] B_DIRTY = 12'h001;
  localparam logic [11:0] IDLE_V  = B_RSTN | B_GATE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, stop_req = 1'b0, cfg_invalidate = 1'b0, phy_ready = 1'b0;
  logic phy_rst, phy_cfg_req, core_rst_n, core_init_req, phy_stream_en;
  logic clk_gate_en, clk_sel, core_en, tg_en, link_up, err, cfg_dirty;

  always #10 clk = ~clk;

  link_bringup_seq #(
    .CLKS_PER_MS(CPM), .RST_MS(RSTMS), .SETTLE_MS(SETMS), .POLL_TRIES(TRIES)
  ) u_link_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .cfg_invalidate(cfg_invalidate), .phy_ready(phy_ready),
    .phy_rst(phy_rst), .phy_cfg_req(phy_cfg_req), .core_rst_n(core_rst_n),
    .core_init_req(core_init_req), .phy_stream_en(phy_stream_en),
    .clk_gate_en(clk_gate_en), .clk_sel(clk_sel), .core_en(core_en),
    .tg_en(tg_en), .link_up(link_up), .err(err), .cfg_dirty(cfg_dirty)
  );

  typedef struct {
    logic [11:0] vec;
    int          len;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit mon_en = 1'b0;
  logic [11:0] last_v;
  int cur_len;
  string cur_tag;
  int hold_cnt;

  function automatic logic [11:0] sample_vec();
    return {phy_rst, phy_cfg_req, core_rst_n, core_init_req, phy_stream_en,
            clk_gate_en, clk_sel, core_en, tg_en, link_up, err, cfg_dirty};
  endfunction

  task automatic push(input logic [11:0] v, input int len, input string tag);
    exp_t e;
    e.vec = v; e.len = len; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares every output change against the expected queue
  always @(negedge clk) begin
    if (mon_en) begin
      logic [11:0] v;
      v = sample_vec();
      if (v !== last_v) begin
        if (cur_len != 0) begin
          n_cmp++;
          if (hold_cnt != cur_len) begin
            n_bad++;
            $display("FAIL %s hold of %h: actual %0d cycles expected %0d", cur_tag, last_v, hold_cnt, cur_len);
          end
        end
        n_cmp++;
        if (q.size() == 0) begin
          n_bad++;
          $display("FAIL R10 unexpected change: actual %h expected %h (no change)", v, last_v);
          cur_len = 0; cur_tag = "R10";
        end else begin
          exp_t e;
          e = q.pop_front();
          if (v !== e.vec) begin
            n_bad++;
            $display("FAIL %s outputs: actual %h expected %h", e.tag, v, e.vec);
          end
          cur_len = e.len; cur_tag = e.tag;
        end
        hold_cnt = 1;
        last_v = v;
      end else begin
        hold_cnt++;
      end
    end
  end

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  function automatic int poll_ms(input int r);
    return (r + CPM) / CPM;
  endfunction

  task automatic push_reload(input logic [11:0] e);
    push(IDLE_V | B_PRST | B_DIRTY | e, RSTMS * CPM, "R2");
    push(IDLE_V | B_DIRTY | e, SETMS * CPM, "R2");
    push(IDLE_V | B_CFG | B_DIRTY | e, 1, "R2");
    push(B_GATE | B_DIRTY | e, RSTMS * CPM, "R3");
    push(IDLE_V | B_DIRTY | e, SETMS * CPM, "R3");
    push(IDLE_V | B_INIT | B_DIRTY | e, 1, "R3");
  endtask

  task automatic push_on(input int k, input string ptag);
    push(IDLE_V | B_STR, k * CPM, ptag);
    push(B_RSTN | B_STR, 1, "R7");
    push(B_RSTN | B_STR | B_SEL, 1, "R7");
    push(B_RSTN | B_STR | B_SEL | B_GATE, 1, "R7");
    push(B_RSTN | B_STR | B_SEL | B_GATE | B_CORE, 1, "R7");
    push(B_RSTN | B_STR | B_SEL | B_GATE | B_CORE | B_TG, 1, "R7");
    push(B_RSTN | B_STR | B_SEL | B_GATE | B_CORE | B_TG | B_UP, 0, "R7");
  endtask

  task automatic push_off(input logic [11:0] d);
    push(B_RSTN | B_STR | B_SEL | B_GATE | d, 1, "R8");
    push(B_RSTN | B_STR | B_SEL | d, 1, "R8");
    push(B_RSTN | B_STR | d, 1, "R8");
    push(B_RSTN | B_STR | B_GATE | d, 1, "R8");
    push(IDLE_V | d, 0, "R8");
  endtask

  task automatic wait_stream();
    do @(negedge clk); while (!phy_stream_en);
  endtask

  task automatic drain(input string tag);
    int t;
    t = 0;
    while (q.size() != 0 && t < 5000) begin
      @(negedge clk); t++;
    end
    n_cmp++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL %s pending items: actual %0d expected 0", tag, q.size());
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset values
    n_cmp++;
    if (sample_vec() !== (IDLE_V | B_DIRTY)) begin
      n_bad++;
      $display("FAIL R1 reset outputs: actual %h expected %h", sample_vec(), IDLE_V | B_DIRTY);
    end
    last_v = sample_vec(); cur_len = 0; cur_tag = "R1"; hold_cnt = 0;
    mon_en = 1'b1;

    // stale start, stray start and stray stop mid-sequence (R2 R3 R5 R7 R10)
    push_reload(12'h000);
    push_on(poll_ms(7), "R5");
    pulse(start_req);
    repeat (RSTMS * CPM + 3) @(negedge clk);
    pulse(start_req);
    wait_stream();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    repeat (5) @(negedge clk);
    phy_ready = 1'b1;
    drain("R7");

    // start while streaming is ignored (R10), invalidate sets stale flag (R9)
    pulse(start_req);
    repeat (10) @(negedge clk);
    push(B_RSTN | B_STR | B_SEL | B_GATE | B_CORE | B_TG | B_UP | B_DIRTY, 0, "R9");
    pulse(cfg_invalidate);
    drain("R9");
    push_off(B_DIRTY);
    phy_ready = 1'b0;
    pulse(stop_req);
    drain("R8");

    // stale again: full reload, lock late within a later millisecond (R5)
    push_reload(12'h000);
    push_on(poll_ms(13), "R5");
    pulse(start_req);
    wait_stream();
    repeat (13) @(negedge clk);
    phy_ready = 1'b1;
    drain("R5");
    push_off(12'h000);
    phy_ready = 1'b0;
    pulse(stop_req);
    drain("R8");

    // stop while idle is ignored (R10)
    pulse(stop_req);
    repeat (20) @(negedge clk);
    drain("R10");

    // clean start skips resets (R4), lock at first sample
    push_on(poll_ms(0), "R4");
    pulse(start_req);
    wait_stream();
    phy_ready = 1'b1;
    drain("R4");
    push_off(12'h000);
    phy_ready = 1'b0;
    pulse(stop_req);
    drain("R8");

    // timeout rolls back and raises err (R6)
    push(IDLE_V | B_STR, TRIES * CPM, "R6");
    push(IDLE_V | B_ERR, 0, "R6");
    pulse(start_req);
    wait_stream();
    pulse(stop_req);
    drain("R6");
    repeat (30) @(negedge clk);
    n_cmp++;
    if (err !== 1'b1) begin
      n_bad++;
      $display("FAIL R6 err held: actual %b expected 1", err);
    end

    // next start clears err, then completes (R6)
    push_on(poll_ms(3), "R6");
    pulse(start_req);
    wait_stream();
    repeat (3) @(negedge clk);
    phy_ready = 1'b1;
    drain("R6");
    push_off(12'h000);
    phy_ready = 1'b0;
    pulse(stop_req);
    drain("R8");

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule